// File: doc/BRIEF.md
# One-to-Many Broadcast Fanout

This block takes a stream of messages from a single producer and hands every message to each of a fixed set of receiver ports. The producer writes through a valid/ready enqueue port into a small internal queue. The message at the head of that queue is presented on every receiver port that still has to take it. A receiver takes it by asserting its acknowledge while its offer is high.

Receivers are independent. They may accept in any order, on any cycle and at any rate. A per-receiver record of which ports already hold the head message stops a fast receiver from seeing the same message twice while a slow one catches up. Once every port has taken the head message, the block spends one release cycle: it clears all records, drops the head and moves to the next message. The producer can write into a free slot during that same release cycle.

Top module: `bcast_fanout`

## Requirements
- R1: During reset and in the first cycle after reset, every `rx_offer` bit is 0 and `in_ready` is 1.
- R2: `rx_offer[i]` is 1 exactly when the queue holds a message and receiver i has not yet accepted it. While any offer is high, `rx_data` carries the oldest queued message and does not change.
- R3: When `rx_offer[i]` and `rx_ack[i]` are both 1 at a clock edge, receiver i has accepted the message. From the next cycle `rx_offer[i]` stays 0 until the head message is released.
- R4: When every receiver has accepted the head message, the following cycle is a release cycle. In that cycle all offers are 0, the head is dropped, and in the next cycle the next queued message, if there is one, is offered on all ports.
- R5: Every receiver gets every enqueued message exactly once, in enqueue order.
- R6: An `rx_ack[i]` is ignored while `rx_offer[i]` is 0, whether the port has already accepted or the queue is empty. It neither changes any offer nor triggers a release early.
- R7: `in_ready` is 0 when the queue holds DEPTH messages. An `in_valid` in that state does not add a message.
- R8: An enqueue and a release in the same cycle both take effect: the occupancy is unchanged and the new message joins the tail.
- R9: While the queue is empty, no port offers anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer has a message on `in_data` |
| in_ready | output | 1 | Queue has a free slot; an enqueue happens when both are 1 |
| in_data | input | DATA_W | Message from the producer |
| rx_offer | output | NUM_RX | Per-receiver offer of the head message |
| rx_ack | input | NUM_RX | Per-receiver acceptance of the offered message |
| rx_data | output | DATA_W | Head message, shared by all receivers |

## Verification
The two functions that can meet in one cycle are the release of a fully delivered head and the enqueue of a new message. Their coincidence is forced by holding `in_valid` and all acknowledges high while messages stream through. It is also reached by random valid and acknowledge patterns that at times fill the queue. A behavioural queue model in the bench decides, cycle by cycle, whether `in_ready`, every offer bit and the head data match. A per-receiver tally confirms that each message arrived once and in order.

// File: rtl/bcast_pkg.sv
// Shared helpers for the broadcast fanout block.
// Assumes indices are small enough to fit in 32 bits.
package bcast_pkg;

    // Advance a circular index, wrapping at depth.
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/bcast_fifo.sv
// Circular message queue with an occupancy counter.
// Does: stores up to DEPTH messages, shows the oldest on head_data.
// Assumes: enq is only raised while not_full, deq only while not_empty;
// enq and deq may both be raised in one cycle.
module bcast_fifo
    import bcast_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  logic [DATA_W-1:0] enq_data,
    input  logic              deq,
    output logic [DATA_W-1:0] head_data,
    output logic              not_empty,
    output logic              not_full,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    // Write the incoming message into the tail slot.
    always_ff @(posedge clk) begin
        if (enq) store[wr_ptr] <= enq_data;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (enq) wr_ptr <= PW'(wrap_next(32'(wr_ptr), DEPTH));
            if (deq) rd_ptr <= PW'(wrap_next(32'(rd_ptr), DEPTH));
            case ({enq, deq})
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    // Status and head outputs.
    always_comb begin
        head_data = store[rd_ptr];
        not_empty = (occ != '0);
        not_full  = (occ != CW'(DEPTH));
    end
endmodule

// File: rtl/bcast_track.sv
// Per-receiver delivery tracker.
// Does: keeps one "already has it" flag per receiver, offers the head to
// ports whose flag is clear, and raises all_done once every flag is set.
// Assumes: head_valid stays 1 from the first acceptance until all_done.
module bcast_track #(
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [NUM_RX-1:0] ack,
    output logic [NUM_RX-1:0] offer,
    output logic              all_done
);
    logic [NUM_RX-1:0] got;

    for (genvar i = 0; i < NUM_RX; i++) begin : g_port
        // Offer the head only to a port that has not yet taken it.
        always_comb offer[i] = head_valid && !got[i];

        // Set the flag on acceptance and clear all flags on release.
        always_ff @(posedge clk) begin
            if (!rst_n)                 got[i] <= 1'b0;
            else if (all_done)          got[i] <= 1'b0;
            else if (offer[i] && ack[i]) got[i] <= 1'b1;
        end
    end

    // Release once every port holds the head message.
    always_comb all_done = &got;
endmodule

// File: rtl/bcast_fanout.sv
// Top of the broadcast fanout.
// Does: queues producer messages and delivers each one to all NUM_RX
// receivers, then drops it in a single release cycle.
// Assumes: receivers sample rx_data in the cycle they acknowledge.
module bcast_fanout #(
    parameter int DATA_W = 16,
    parameter int NUM_RX = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [NUM_RX-1:0] rx_offer,
    input  logic [NUM_RX-1:0] rx_ack,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          enq;
    logic          release_head;
    logic          head_valid;
    logic          q_not_full;
    logic [CW-1:0] q_occ;

    // Accept a producer message whenever a slot is free.
    always_comb begin
        in_ready = q_not_full;
        enq      = in_valid && q_not_full;
    end

    bcast_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq      (enq),
        .enq_data (in_data),
        .deq      (release_head),
        .head_data(rx_data),
        .not_empty(head_valid),
        .not_full (q_not_full),
        .occ      (q_occ)
    );

    bcast_track #(.NUM_RX(NUM_RX)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_valid(head_valid),
        .ack       (rx_ack),
        .offer     (rx_offer),
        .all_done  (release_head)
    );
endmodule

// File: rtl/bcast_fanout_chk.sv
// Property checker for bcast_fanout, attached by bind.
module bcast_fanout_chk #(
    parameter int DATA_W = 16,
    parameter int NUM_RX = 4,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [NUM_RX-1:0]          rx_offer,
    input logic [NUM_RX-1:0]          rx_ack,
    input logic [DATA_W-1:0]          rx_data,
    input logic                       release_head,
    input logic                       head_valid,
    input logic [$clog2(DEPTH+1)-1:0] q_occ
);
    // R9
    no_offer_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> (rx_offer == '0));

    // R3
    offer_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_offer & rx_ack) != '0) |=> ((rx_offer & $past(rx_offer & rx_ack)) == '0));

    // R4
    release_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_head |-> (rx_offer == '0));

    // R2
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_offer != '0) |=> ((rx_offer == '0) || $stable(rx_data)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !release_head) |=> !in_ready);

    // R8
    enq_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_head && in_valid && in_ready) |=> (q_occ == $past(q_occ)));
endmodule

bind bcast_fanout bcast_fanout_chk #(.DATA_W(DATA_W), .NUM_RX(NUM_RX), .DEPTH(DEPTH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .rx_offer    (rx_offer),
    .rx_ack      (rx_ack),
    .rx_data     (rx_data),
    .release_head(release_head),
    .head_valid  (head_valid),
    .q_occ       (q_occ)
);

// File: tb/test_bcast_fanout.sv
module test_bcast_fanout;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NR = 4;
    localparam int DP = 4;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [NR-1:0] rx_offer;
    logic [NR-1:0] rx_ack = '0;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [DW-1:0] mq[$];
    logic [DW-1:0] sent[$];
    bit            mflag[NR];
    int            got_cnt[NR];
    logic [DW-1:0] next_val = 16'h1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcast_fanout #(.DATA_W(DW), .NUM_RX(NR), .DEPTH(DP)) i_bcast_fanout (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .rx_offer(rx_offer), .rx_ack(rx_ack), .rx_data(rx_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NR-1:0] exp_offer();
        logic [NR-1:0] v = '0;
        for (int i = 0; i < NR; i++) v[i] = (mq.size() > 0) && !mflag[i];
        return v;
    endfunction

    // One cycle: drive at the falling edge, compare, then step the model at the rising edge.
    task automatic cyc(input bit v, input bit [NR-1:0] a, input string tag);
        logic [NR-1:0] eo;
        bit done;
        bit acc;
        in_valid = v;
        in_data  = next_val;
        rx_ack   = a;
        #1;
        eo = exp_offer();
        check(in_ready == (mq.size() < DP), tag, "in_ready", in_ready, (mq.size() < DP));
        check(rx_offer == eo, tag, "rx_offer", rx_offer, eo);
        if (eo != '0) check(rx_data == mq[0], tag, "rx_data", rx_data, mq[0]);
        // R5: every acceptance must carry the next message in send order for that port
        for (int i = 0; i < NR; i++) begin
            if (rx_offer[i] && a[i]) begin
                if (got_cnt[i] < sent.size())
                    check(rx_data == sent[got_cnt[i]], "R5", "delivered data", rx_data, sent[got_cnt[i]]);
                else
                    check(1'b0, "R5", "delivery beyond sent", got_cnt[i], sent.size());
                got_cnt[i]++;
            end
        end
        @(posedge clk);
        done = (mq.size() > 0);
        for (int i = 0; i < NR; i++) done = done && mflag[i];
        acc = v && (mq.size() < DP);
        for (int i = 0; i < NR; i++) begin
            if (done) mflag[i] = 1'b0;
            else if (mq.size() > 0 && !mflag[i] && a[i]) mflag[i] = 1'b1;
        end
        if (done) void'(mq.pop_front());
        if (acc) begin
            mq.push_back(next_val);
            sent.push_back(next_val);
            next_val = next_val + 16'h0101;
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin mflag[i] = 1'b0; got_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(rx_offer == '0, "R1", "offer in reset", rx_offer, 0);
        check(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_offer == '0, "R1", "offer after reset", rx_offer, 0);
        check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

        // R9 and R6: acknowledges on an empty queue are ignored
        repeat (3) cyc(1'b0, '1, "R9");

        // R2, R3, R4: one message, staggered acceptance
        cyc(1'b1, 4'b0000, "R2");
        cyc(1'b0, 4'b0100, "R3");
        cyc(1'b0, 4'b0001, "R3");
        cyc(1'b0, 4'b0000, "R2");
        cyc(1'b0, 4'b1010, "R3");
        cyc(1'b0, 4'b0000, "R4");
        cyc(1'b0, 4'b0000, "R9");

        // R6: repeated acks on ports that already accepted do not release early
        cyc(1'b1, 4'b0000, "R6");
        cyc(1'b0, 4'b0001, "R6");
        cyc(1'b0, 4'b0001, "R6");
        cyc(1'b0, 4'b0110, "R6");
        cyc(1'b0, 4'b0111, "R6");
        cyc(1'b0, 4'b0111, "R6");
        cyc(1'b0, 4'b1000, "R6");
        cyc(1'b0, 4'b0000, "R4");

        // R7: fill with no acceptance, then keep pushing
        repeat (DP + 3) cyc(1'b1, 4'b0000, "R7");
        repeat (4 * DP) cyc(1'b0, 4'b1111, "R7");

        // R8: streaming with every receiver always accepting
        repeat (3 * DP + 8) cyc(1'b1, 4'b1111, "R8");

        // R8: fill, then release while the producer keeps offering
        repeat (DP) cyc(1'b1, 4'b0000, "R8");
        repeat (12) cyc(1'b1, 4'b1111, "R8");

        // Random valid and acknowledge patterns
        for (int k = 0; k < 300; k++)
            cyc(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), "R2");

        // Drain, then R5 totals
        repeat (6 * DP) cyc(1'b0, 4'b1111, "R5");
        for (int i = 0; i < NR; i++)
            check(got_cnt[i] == sent.size(), "R5", "delivery count", got_cnt[i], sent.size());

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule